// File: doc/BRIEF.md
# Program ROM Bank Mapper

This block sits between a CPU address bus and a program ROM and turns each CPU address in the range 0x6000 to 0xFFFF into a ROM page number, with pages 8 KB in size. Four 7-bit bank registers and a small mode register, loaded through a simple write port, decide which ROM pages are visible. The mode chooses how the upper 32 KB (0x8000 to 0xFFFF) is split: one 32 KB bank, two 16 KB banks or four 8 KB banks. One of the 8 KB settings reverses the bit order of every bank number before use.

The final bank of the upper area is either pinned to the top of the ROM or taken from bank register 3, as a mode bit selects. A second mode bit opens the 8 KB window at 0x6000 to 0x7FFF onto a ROM page derived from bank register 3. The mapping from address to page is purely combinational. Register writes take effect on the clock edge that captures them. The ROM size is a parameter, given as the number of page-number bits. Page arithmetic wraps modulo the page count.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset all bank registers and the mode register hold zero. With PAGE_W=7, the four 8 KB slots of 0x8000 to 0xFFFF then map in order to pages 124, 125, 126 and 127, and the window at 0x6000 to 0x7FFF is not selected.
- R2: A write with bankWe high loads bank register wrIdx with wrData[6:0]. Bit 7 of the data is dropped, and the other three bank registers keep their values.
- R3: A write with modeWe high keeps wrData[1:0] as the granularity, wrData[2] as the last-bank select and wrData[7] as the window enable. Data bits 6:3 have no effect on any output.
- R4: Granularity 0 (32 KB): for an address at or above 0x8000, the page is last×4 + cpuAddr[14:13].
- R5: Granularity 1 (16 KB): addresses 0x8000 to 0xBFFF map to page bank1×2 + cpuAddr[13]. Addresses 0xC000 to 0xFFFF map to page last×2 + cpuAddr[13].
- R6: Granularity 2 (8 KB): slots 0, 1 and 2 (selected by cpuAddr[14:13]) use bank registers 0, 1 and 2 directly. Slot 3 uses last.
- R7: Granularity 3 works like granularity 2, except that every bank value (including bank 3 where it is used) is bit-reversed first. Input bits 0,1,2,4,5,6 go to bits 6,5,4,2,1,0, and bit 3 becomes zero.
- R8: With mode bit 2 set, last is (effective) bank register 3. With it clear, last is the highest ROM page (all ones).
- R9: With the window enable set, addresses 0x6000 to 0x7FFF map to page bank3×4+3 (32 KB), bank3×2+1 (16 KB) or bank3 (8 KB settings), and winEn and romSel are both high.
- R10: romSel is high only for addresses at or above 0x8000, or inside 0x6000 to 0x7FFF with the window enabled. Otherwise romSel and winEn are low and romPage is zero.
- R11: Page numbers wrap modulo 2^PAGE_W.
- R12: Outputs follow cpuAddr in the same cycle, and a register write is visible on the outputs from the cycle after its capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bankWe | input | 1 | Write strobe for the bank register picked by wrIdx |
| modeWe | input | 1 | Write strobe for the mode register |
| wrIdx | input | 2 | Bank register index |
| wrData | input | 8 | Write data |
| cpuAddr | input | 16 | CPU address |
| romPage | output | PAGE_W | ROM address bits 13 and up (page number) |
| romSel | output | 1 | ROM is the target of this address |
| winEn | output | 1 | Address falls in the enabled 0x6000 window |

## Verification
The bench goes after the places where page arithmetic can quietly go wrong. A fixed last bank that is taken as zero instead of all ones would put the 32 KB and 16 KB upper slots at the bottom of the ROM. A bit reversal that keeps bit 3, or that swaps the wrong pairs, would map reversed banks onto neighbouring pages. A window formula that ignores granularity would land on the even page, or on a page off by three. Overflowing bank values such as 0x7F times four check that the page wraps and does not saturate. Writes with data bit 7 set, or with mode bits 6:3 set, check that the dropped bits never leak into a page or into the window enable.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  localparam int BANK_W = 7;
  localparam int BANKS  = 4;

  typedef enum logic [1:0] {
    GRAN_32K    = 2'd0,
    GRAN_16K    = 2'd1,
    GRAN_8K     = 2'd2,
    GRAN_8K_REV = 2'd3
  } granT;

  // strobes from control to the register datapath
  typedef struct packed {
    logic [BANKS-1:0] bankLoad;
    logic             modeLoad;
    logic [7:0]       data;
  } pbmStrobeT;

  // address region decode
  typedef struct packed {
    logic       upperHit;
    logic       winRange;
    logic [1:0] slot;
  } pbmRegionT;

  function automatic logic [BANK_W-1:0] reverseBank(input logic [BANK_W-1:0] v);
    logic [BANK_W-1:0] r;
    r    = '0;
    r[6] = v[0];
    r[5] = v[1];
    r[4] = v[2];
    r[2] = v[4];
    r[1] = v[5];
    r[0] = v[6];
    return r;
  endfunction

endpackage

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
  import pbm_pkg::*;
(
  input  logic             bankWe,
  input  logic             modeWe,
  input  logic [1:0]       wrIdx,
  input  logic [7:0]       wrData,
  input  logic [15:0]      cpuAddr,
  output pbmStrobeT        strobe,
  output pbmRegionT        region
);

  genvar gi;
  generate
    for (gi = 0; gi < BANKS; gi++) begin : g_dec
      assign strobe.bankLoad[gi] = bankWe && (wrIdx == gi[1:0]);
    end
  endgenerate

  assign strobe.modeLoad = modeWe;
  assign strobe.data     = wrData;

  assign region.upperHit = cpuAddr[15];
  assign region.winRange = (cpuAddr[15:13] == 3'b011);
  assign region.slot     = cpuAddr[14:13];

  logic unusedLowAddr;
  assign unusedLowAddr = ^cpuAddr[12:0];

endmodule

// File: rtl/pbm_regs.sv
module pbm_regs
  import pbm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  pbmStrobeT                    strobe,
  output logic [BANKS-1:0][BANK_W-1:0] bankQ,
  output granT                         gran,
  output logic                         lastSel,
  output logic                         winOn
);

  genvar gi;
  generate
    for (gi = 0; gi < BANKS; gi++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n)                    bankQ[gi] <= '0;
        else if (strobe.bankLoad[gi])  bankQ[gi] <= strobe.data[BANK_W-1:0];
      end

      // R2
      bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe.bankLoad[gi] |=> bankQ[gi] == $past(strobe.data[BANK_W-1:0]));

      // R2
      bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe.bankLoad[gi] |=> $stable(bankQ[gi]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gran    <= GRAN_32K;
      lastSel <= 1'b0;
      winOn   <= 1'b0;
    end else if (strobe.modeLoad) begin
      gran    <= granT'(strobe.data[1:0]);
      lastSel <= strobe.data[2];
      winOn   <= strobe.data[7];
    end
  end

  // R3
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.modeLoad |=> {winOn, lastSel, gran} ==
                        $past({strobe.data[7], strobe.data[2:0]}));

endmodule

// File: rtl/pbm_xlate.sv
module pbm_xlate
  import pbm_pkg::*;
#(
  parameter int PAGE_W = 7
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [BANKS-1:0][BANK_W-1:0] bankQ,
  input  granT                         gran,
  input  logic                         lastSel,
  input  logic                         winOn,
  input  pbmRegionT                    region,
  output logic [PAGE_W-1:0]            romPage,
  output logic                         romSel,
  output logic                         winEn
);

  localparam int EXT_W = ((PAGE_W > BANK_W) ? PAGE_W : BANK_W) + 2;

  logic [BANKS-1:0][EXT_W-1:0] effBank;
  logic [EXT_W-1:0]            lastVal;
  logic [EXT_W-1:0]            upPage;
  logic [EXT_W-1:0]            winPage;

  genvar gi;
  generate
    for (gi = 0; gi < BANKS; gi++) begin : g_eff
      assign effBank[gi] = (gran == GRAN_8K_REV) ?
                           EXT_W'(reverseBank(bankQ[gi])) : EXT_W'(bankQ[gi]);
    end
  endgenerate

  assign lastVal = lastSel ? effBank[3] : '1;

  always_comb begin
    upPage = '0;
    case (gran)
      GRAN_32K: upPage = (lastVal << 2) + EXT_W'(region.slot);
      GRAN_16K: upPage = ((region.slot[1] ? lastVal : effBank[1]) << 1)
                         + EXT_W'(region.slot[0]);
      default: begin
        case (region.slot)
          2'd0:    upPage = effBank[0];
          2'd1:    upPage = effBank[1];
          2'd2:    upPage = effBank[2];
          default: upPage = lastVal;
        endcase
      end
    endcase
  end

  always_comb begin
    case (gran)
      GRAN_32K: winPage = (effBank[3] << 2) + EXT_W'(3);
      GRAN_16K: winPage = (effBank[3] << 1) + EXT_W'(1);
      default:  winPage = effBank[3];
    endcase
  end

  assign winEn  = region.winRange && winOn;
  assign romSel = region.upperHit || winEn;

  always_comb begin
    if (region.upperHit)   romPage = upPage[PAGE_W-1:0];
    else if (winEn)        romPage = winPage[PAGE_W-1:0];
    else                   romPage = '0;
  end

  // R10
  win_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!winOn && !region.upperHit) |-> (!romSel && romPage == '0));

  // R4
  gran32_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region.upperHit && gran == GRAN_32K) |-> romPage[1:0] == region.slot);

  // R8
  top_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (region.upperHit && gran[1] && !lastSel && region.slot == 2'd3)
      |-> romPage == '1);

  // R9
  win_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (winEn && gran == GRAN_16K) |-> (romPage[0] && romSel));

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import pbm_pkg::*;
#(
  parameter int PAGE_W = 7
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bankWe,
  input  logic              modeWe,
  input  logic [1:0]        wrIdx,
  input  logic [7:0]        wrData,
  input  logic [15:0]       cpuAddr,
  output logic [PAGE_W-1:0] romPage,
  output logic              romSel,
  output logic              winEn
);

  pbmStrobeT                    strobe;
  pbmRegionT                    region;
  logic [BANKS-1:0][BANK_W-1:0] bankQ;
  granT                         gran;
  logic                         lastSel;
  logic                         winOn;

  pbm_ctrl u_ctrl (
    .bankWe  (bankWe),
    .modeWe  (modeWe),
    .wrIdx   (wrIdx),
    .wrData  (wrData),
    .cpuAddr (cpuAddr),
    .strobe  (strobe),
    .region  (region)
  );

  pbm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .bankQ   (bankQ),
    .gran    (gran),
    .lastSel (lastSel),
    .winOn   (winOn)
  );

  pbm_xlate #(.PAGE_W(PAGE_W)) u_xlate (
    .clk     (clk),
    .rst_n   (rst_n),
    .bankQ   (bankQ),
    .gran    (gran),
    .lastSel (lastSel),
    .winOn   (winOn),
    .region  (region),
    .romPage (romPage),
    .romSel  (romSel),
    .winEn   (winEn)
  );

  // R10
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    romSel |-> (cpuAddr[15] || cpuAddr[14:13] == 2'b11));

  // R9
  win_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    winEn |-> (romSel && !cpuAddr[15]));

endmodule

// File: tb/prg_bank_mapper_tb.sv
`timescale 1ns/1ps
module prg_bank_mapper_tb_top;

  localparam int PAGE_W = 7;
  localparam int NP     = 1 << PAGE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bankWe = 1'b0;
  logic              modeWe = 1'b0;
  logic [1:0]        wrIdx = '0;
  logic [7:0]        wrData = '0;
  logic [15:0]       cpuAddr = '0;
  logic [PAGE_W-1:0] romPage;
  logic              romSel;
  logic              winEn;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  prg_bank_mapper #(.PAGE_W(PAGE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bankWe(bankWe), .modeWe(modeWe),
    .wrIdx(wrIdx), .wrData(wrData), .cpuAddr(cpuAddr),
    .romPage(romPage), .romSel(romSel), .winEn(winEn)
  );

  // behavioural reference state
  int mBank[4] = '{0, 0, 0, 0};
  int mGran = 0;
  int mLast = 0;
  int mWin  = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mBank[k]) mBank[k] = 0;
      mGran = 0; mLast = 0; mWin = 0;
    end else begin
      if (bankWe) mBank[wrIdx] = wrData & 127;
      if (modeWe) begin
        mGran = wrData & 3;
        mLast = (wrData >> 2) & 1;
        mWin  = (wrData >> 7) & 1;
      end
    end
  end

  function automatic int revBits(int v);
    int r = 0;
    if (v & 1)  r |= 64;
    if (v & 2)  r |= 32;
    if (v & 4)  r |= 16;
    if (v & 16) r |= 4;
    if (v & 32) r |= 2;
    if (v & 64) r |= 1;
    return r;
  endfunction

  function automatic int eff(int i);
    return (mGran == 3) ? revBits(mBank[i]) : mBank[i];
  endfunction

  // returns page; sel and win through outputs
  function automatic int model(int a, output bit sel, output bit win);
    int p = 0;
    int slot = (a >> 13) & 3;
    int last = mLast ? eff(3) : -1;
    sel = 0; win = 0;
    if (a >= 'h8000) begin
      sel = 1;
      if (mGran == 0)      p = last * 4 + slot;
      else if (mGran == 1) p = ((slot < 2) ? eff(1) : last) * 2 + slot % 2;
      else                 p = (slot == 3) ? last : eff(slot);
    end else if (a >= 'h6000 && mWin != 0) begin
      sel = 1; win = 1;
      if (mGran == 0)      p = eff(3) * 4 + 3;
      else if (mGran == 1) p = eff(3) * 2 + 1;
      else                 p = eff(3);
    end
    return ((p % NP) + NP) % NP;
  endfunction

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (checking && !finished) begin
      bit s, w;
      int p;
      string tag;
      p = model(int'(cpuAddr), s, w);
      if (!s)              tag = "R10";
      else if (w)          tag = "R9";
      else if (mGran == 3) tag = "R7";
      else if (mGran == 2) tag = "R6";
      else if (mGran == 1) tag = "R5";
      else                 tag = "R4";
      checks++;
      if (romPage != p[PAGE_W-1:0] || romSel != s || winEn != w) begin
        errors++;
        $display("FAIL %s/R12 addr=%h: page=%0d sel=%0b win=%0b expected page=%0d sel=%0b win=%0b",
                 tag, cpuAddr, romPage, romSel, winEn, p, s, w);
      end
    end
  end

  task automatic writeBank(int idx, int val);
    bankWe = 1'b1; wrIdx = idx[1:0]; wrData = val[7:0];
    @(posedge clk); #1;
    bankWe = 1'b0;
  endtask

  task automatic writeMode(int val);
    modeWe = 1'b1; wrData = val[7:0];
    @(posedge clk); #1;
    modeWe = 1'b0;
  endtask

  // directed check with a hand-computed expectation
  task automatic expectAt(string tag, int a, int page, bit sel);
    bit win;
    win = sel && (a < 'h8000);
    cpuAddr = a[15:0];
    @(negedge clk);
    checks++;
    if (romPage != page[PAGE_W-1:0] || romSel != sel || winEn != win) begin
      errors++;
      $display("FAIL %s addr=%h: page=%0d sel=%0b win=%0b expected page=%0d sel=%0b win=%0b",
               tag, a[15:0], romPage, romSel, winEn, page, sel, win);
    end
    @(posedge clk); #1;
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    checking = 1'b1;

    // R1 reset state
    expectAt("R1", 'h8000, 124, 1);
    expectAt("R1", 'hE000, 127, 1);
    expectAt("R1", 'h6000, 0, 0);
    // R10 below window never selected
    expectAt("R10", 'h5FFF, 0, 0);

    // R2 bit 7 dropped, index respected
    writeBank(1, 'hFF);
    writeMode('h02);
    expectAt("R2", 'hA000, 127, 1);
    expectAt("R2", 'h8000, 0, 1);

    // R3 bits 6:3 ignored
    writeMode('h7A);
    expectAt("R3", 'hE000, 127, 1);
    expectAt("R3", 'h6000, 0, 0);

    // R6 direct 8 KB banks
    writeBank(0, 3);
    writeBank(2, 9);
    expectAt("R6", 'h8000, 3, 1);
    expectAt("R6", 'hC000, 9, 1);

    // R7 bit reversal
    writeMode('h03);
    writeBank(0, 'h01);
    expectAt("R7", 'h8000, 64, 1);
    writeBank(0, 'h08);
    expectAt("R7", 'h8000, 0, 1);
    expectAt("R7", 'hA000, 119, 1);

    // R8 last-bank select
    writeBank(3, 5);
    writeMode('h06);
    expectAt("R8", 'hE000, 5, 1);
    writeMode('h02);
    expectAt("R8", 'hE000, 127, 1);

    // R5 16 KB
    writeBank(1, 10);
    writeMode('h01);
    expectAt("R5", 'h8000, 20, 1);
    expectAt("R5", 'hA000, 21, 1);
    expectAt("R5", 'hC000, 126, 1);
    expectAt("R5", 'hE000, 127, 1);
    writeMode('h05);
    expectAt("R8", 'hC000, 10, 1);
    expectAt("R8", 'hE000, 11, 1);

    // R4 32 KB with last = bank3
    writeMode('h04);
    expectAt("R4", 'h8000, 20, 1);
    expectAt("R4", 'hE000, 23, 1);

    // R9 window pages per granularity
    writeMode('h80);
    expectAt("R9", 'h6000, 23, 1);
    writeMode('h81);
    expectAt("R9", 'h7FFF, 11, 1);
    writeMode('h82);
    expectAt("R9", 'h6000, 5, 1);
    writeMode('h83);
    expectAt("R9", 'h6000, 80, 1);

    // R11 wrap
    writeBank(3, 'h7F);
    writeMode('hC4);
    expectAt("R11", 'h8000, 124, 1);
    expectAt("R11", 'hA000, 125, 1);
    expectAt("R11", 'h6000, 127, 1);

    // R12 randomised traffic, compared every clock
    for (int k = 0; k < 3000; k++) begin
      bankWe  = ($urandom % 4) == 0;
      modeWe  = ($urandom % 8) == 0;
      wrIdx   = 2'($urandom);
      wrData  = 8'($urandom);
      cpuAddr = 16'($urandom);
      @(posedge clk); #1;
    end
    bankWe = 1'b0; modeWe = 1'b0;
    @(negedge clk);
    finish();
  end

endmodule